// File: doc/BRIEF.md
# Event Count Profile Comparator

This block checks whether a program run still looks like the run it was profiled from. It is given six 64-bit final event counts taken at the end of a run. It is also given six 64-bit reference counts, which are the final values saved at the end of an earlier trusted profiling run. A start strobe makes the block take a snapshot of all twelve values. It then checks one event per cycle against a relative tolerance. When it finishes it reports one deviation flag per event, an overall tamper flag and a one-cycle done pulse. If any single event is out of tolerance, the whole run counts as modified.

The tolerance is a percentage held in a run-time register. It resets to 5. The deviation test uses no divider: an event deviates when |measured − reference| × 100 > tolerance × reference. The compare is done in a width that cannot overflow. A zero reference therefore flags any nonzero measured count and passes a zero one.

Top module: `evt_profile_cmp`

## Requirements
- R1: After reset, `dev_flags` is 0, `tamper` is 0, `done` is 0, `busy` is 0 and the tolerance register holds 5.
- R2: Event i is flagged exactly when |meas_i − ref_i| × 100 > tol × ref_i, with no overflow for any 64-bit inputs. A difference that is exactly equal to tol percent passes.
- R3: A zero reference with a nonzero measured count is flagged. A zero reference with a zero measured count is not flagged.
- R4: When `done` is high, `tamper` equals the OR of all six `dev_flags` bits.
- R5: Events are checked in a fixed order, one per cycle: index 0 instructions retired, 1 branches retired, 2 data cache writes, 3 completed I/O operations, 4 floating-point operations, 5 calls plus returns. The flag for event i is updated at the (i+1)-th rising edge after the edge that accepts start.
- R6: `done` is a one-cycle pulse that rises at the 7th rising edge after the accepting edge. `busy` is high from the accepting edge until that edge.
- R7: A start that arrives while `busy` is high is ignored and does not cause a second done pulse.
- R8: `dev_flags` and `tamper` stay unchanged after done until the next accepted start. Accepting a start clears both.
- R9: A write to the tolerance register (`tol_wr_en` with `tol_wr_pct`) takes effect only while idle. A write while `busy` is high is dropped.
- R10: Counts and references are captured on the accepting edge. Changes to `meas_cnt` or `ref_cnt` during a check have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe; accepted when idle |
| tol_wr_en | input | 1 | Tolerance register write enable |
| tol_wr_pct | input | 8 | New tolerance in percent |
| meas_cnt | input | 384 | Measured counts; event i in bits [64i+63:64i] |
| ref_cnt | input | 384 | Reference counts; event i in bits [64i+63:64i] |
| dev_flags | output | 6 | Per-event deviation flags, bit i for event i |
| tamper | output | 1 | Overall flag: any event deviated |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Check in progress |

## Verification
The bound checker watches, on every cycle, the relations that hold at all times. These are: done is a single-cycle pulse that follows busy; tamper agrees with the per-event flags at done; the flags and tamper hold while idle without a start; they are cleared when a run begins; the tolerance register is frozen while busy; and busy only rises after a start. The arithmetic boundary cases can only be shown by the bench scenarios. These include the exact-tolerance equality, zero references, full-scale 64-bit values without overflow, and a changed tolerance. The same holds for the event order, the dropped start and tolerance writes during a run, and the snapshot that ignores input changes.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_FIN  = 2'd2
    } cmp_state_t;

    typedef enum logic [2:0] {
        EV_INSTR  = 3'd0,
        EV_BRANCH = 3'd1,
        EV_DWRITE = 3'd2,
        EV_IO     = 3'd3,
        EV_FLOP   = 3'd4,
        EV_CALLRT = 3'd5
    } evt_id_t;

    localparam int PCT_SCALE = 100;
    localparam int SCALE_W   = 7;

    function automatic logic [63:0] abs_diff64(input logic [63:0] a, input logic [63:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/evt_snapshot.sv
module evt_snapshot #(
    parameter int N_EVT = 6,
    parameter int CNT_W = 64,
    localparam int BUS_W = N_EVT * CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [BUS_W-1:0] meas_in,
    input  logic [BUS_W-1:0] ref_in,
    output logic [BUS_W-1:0] meas_q,
    output logic [BUS_W-1:0] ref_q
);

    for (genvar g = 0; g < N_EVT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                meas_q[g*CNT_W +: CNT_W] <= '0;
                ref_q[g*CNT_W +: CNT_W]  <= '0;
            end else if (load) begin
                meas_q[g*CNT_W +: CNT_W] <= meas_in[g*CNT_W +: CNT_W];
                ref_q[g*CNT_W +: CNT_W]  <= ref_in[g*CNT_W +: CNT_W];
            end
        end
    end

endmodule

// File: rtl/evt_dev_eval.sv
module evt_dev_eval #(
    parameter int CNT_W = 64,
    parameter int PCT_W = 8,
    localparam int MUL_W = (PCT_W > evt_cmp_pkg::SCALE_W) ? PCT_W : evt_cmp_pkg::SCALE_W,
    localparam int CMP_W = CNT_W + MUL_W + 1
) (
    input  logic [CNT_W-1:0] meas,
    input  logic [CNT_W-1:0] refv,
    input  logic [PCT_W-1:0] pct,
    output logic             deviates
);
    import evt_cmp_pkg::*;

    logic [CNT_W-1:0] diff;
    logic [CMP_W-1:0] lhs;
    logic [CMP_W-1:0] rhs;

    always_comb begin
        diff = (meas > refv) ? (meas - refv) : (refv - meas);
        lhs  = CMP_W'(diff) * CMP_W'(PCT_SCALE);
        rhs  = CMP_W'(refv) * CMP_W'(pct);
        deviates = (lhs > rhs);
    end

endmodule

// File: rtl/evt_seq_ctrl.sv
module evt_seq_ctrl #(
    parameter int N_EVT = 6,
    localparam int IDX_W = (N_EVT > 1) ? $clog2(N_EVT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             accept,
    output logic             busy,
    output logic             eval_vld,
    output logic [IDX_W-1:0] eval_idx,
    output logic             fin,
    output logic             done
);
    import evt_cmp_pkg::*;

    cmp_state_t st;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            idx_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= (st == ST_FIN);
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st    <= ST_EVAL;
                        idx_q <= '0;
                    end
                end
                ST_EVAL: begin
                    if (idx_q == IDX_W'(N_EVT - 1)) begin
                        st <= ST_FIN;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign accept   = (st == ST_IDLE) && start;
    assign busy     = (st != ST_IDLE);
    assign eval_vld = (st == ST_EVAL);
    assign eval_idx = idx_q;
    assign fin      = (st == ST_FIN);

endmodule

// File: rtl/evt_profile_cmp.sv
module evt_profile_cmp #(
    parameter int N_EVT   = 6,
    parameter int CNT_W   = 64,
    parameter int PCT_W   = 8,
    parameter int TOL_RST = 5,
    localparam int BUS_W  = N_EVT * CNT_W,
    localparam int IDX_W  = (N_EVT > 1) ? $clog2(N_EVT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             tol_wr_en,
    input  logic [PCT_W-1:0] tol_wr_pct,
    input  logic [BUS_W-1:0] meas_cnt,
    input  logic [BUS_W-1:0] ref_cnt,
    output logic [N_EVT-1:0] dev_flags,
    output logic             tamper,
    output logic             done,
    output logic             busy
);

    logic             accept;
    logic             eval_vld;
    logic [IDX_W-1:0] eval_idx;
    logic             fin;
    logic [BUS_W-1:0] snap_meas;
    logic [BUS_W-1:0] snap_ref;
    logic [CNT_W-1:0] sel_meas;
    logic [CNT_W-1:0] sel_ref;
    logic             sel_dev;
    logic [PCT_W-1:0] tol_q;

    evt_seq_ctrl #(.N_EVT(N_EVT)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .accept   (accept),
        .busy     (busy),
        .eval_vld (eval_vld),
        .eval_idx (eval_idx),
        .fin      (fin),
        .done     (done)
    );

    evt_snapshot #(.N_EVT(N_EVT), .CNT_W(CNT_W)) u_snap (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .meas_in (meas_cnt),
        .ref_in  (ref_cnt),
        .meas_q  (snap_meas),
        .ref_q   (snap_ref)
    );

    always_comb begin
        sel_meas = snap_meas[int'(eval_idx) * CNT_W +: CNT_W];
        sel_ref  = snap_ref[int'(eval_idx) * CNT_W +: CNT_W];
    end

    evt_dev_eval #(.CNT_W(CNT_W), .PCT_W(PCT_W)) u_eval (
        .meas     (sel_meas),
        .refv     (sel_ref),
        .pct      (tol_q),
        .deviates (sel_dev)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tol_q <= PCT_W'(TOL_RST);
        end else if (tol_wr_en && !busy) begin
            tol_q <= tol_wr_pct;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_flags <= '0;
            tamper    <= 1'b0;
        end else if (accept) begin
            dev_flags <= '0;
            tamper    <= 1'b0;
        end else begin
            if (eval_vld) begin
                dev_flags[eval_idx] <= sel_dev;
            end
            if (fin) begin
                tamper <= |dev_flags;
            end
        end
    end

endmodule

// File: rtl/evt_cmp_chk.sv
module evt_cmp_chk #(
    parameter int N_EVT = 6,
    parameter int PCT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             tamper,
    input logic [N_EVT-1:0] dev_flags,
    input logic [PCT_W-1:0] tol_q
);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    assert_tamper_or_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (tamper == (|dev_flags)));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(dev_flags) && $stable(tamper)));

    assert_clear_on_run_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (dev_flags == '0 && !tamper));

    assert_busy_needs_start_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_tol_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(tol_q));

endmodule

bind evt_profile_cmp evt_cmp_chk #(.N_EVT(N_EVT), .PCT_W(PCT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .tamper    (tamper),
    .dev_flags (dev_flags),
    .tol_q     (tol_q)
);

// File: tb/evt_profile_cmp_tb.sv
module evt_profile_cmp_tb;
    localparam int NE = 6;
    localparam int CW = 64;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             tol_wr_en = 1'b0;
    logic [7:0]       tol_wr_pct = '0;
    logic [NE*CW-1:0] meas = '0;
    logic [NE*CW-1:0] refc = '0;
    logic [NE-1:0]    dev_flags;
    logic             tamper, done, busy;

    int n_tests = 0;
    int n_fail  = 0;
    int done_cnt = 0;

    evt_profile_cmp u_dut (
        .clk(clk), .rst(rst), .start(start),
        .tol_wr_en(tol_wr_en), .tol_wr_pct(tol_wr_pct),
        .meas_cnt(meas), .ref_cnt(refc),
        .dev_flags(dev_flags), .tamper(tamper), .done(done), .busy(busy)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---- behavioural reference model ----
    logic [CW-1:0] mm [NE];
    logic [CW-1:0] mr [NE];
    int            ph = -1;
    int            e_tol = 5;
    logic [NE-1:0] e_flags = '0;
    logic          e_tamper = 1'b0;
    logic          e_done = 1'b0;

    function automatic bit model_dev(input logic [63:0] m, input logic [63:0] r, input int t);
        logic [127:0] d;
        d = (m > r) ? {64'd0, m - r} : {64'd0, r - m};
        return (d * 128'd100) > ({64'd0, r} * 128'(t));
    endfunction

    always @(posedge clk) begin
        bit was_busy;
        if (rst) begin
            ph = -1; e_tol = 5; e_flags = '0; e_tamper = 0; e_done = 0;
        end else begin
            was_busy = (ph != -1);
            e_done = 0;
            if (ph >= 0 && ph < NE) begin
                e_flags[ph] = model_dev(mm[ph], mr[ph], e_tol);
                ph++;
            end else if (ph == NE) begin
                e_done = 1; e_tamper = |e_flags; ph = -1;
            end else if (start) begin
                for (int i = 0; i < NE; i++) begin
                    mm[i] = meas[i*CW +: CW];
                    mr[i] = refc[i*CW +: CW];
                end
                e_flags = '0; e_tamper = 0; ph = 0;
            end
            if (tol_wr_en && !was_busy) e_tol = int'(tol_wr_pct);
        end
        #1;
        if (!rst) begin
            chk("R2/R5 dev_flags per cycle", 64'(dev_flags), 64'(e_flags));
            chk("R4 tamper per cycle", 64'(tamper), 64'(e_tamper));
            chk("R6 done per cycle", 64'(done), 64'(e_done));
            chk("R7 busy per cycle", 64'(busy), 64'(ph != -1));
            if (done) done_cnt++;
        end
    end

    // ---- stimulus helpers ----
    task automatic set_ev(input int i, input logic [63:0] m, input logic [63:0] r);
        meas[i*CW +: CW] = m;
        refc[i*CW +: CW] = r;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done();
        for (int n = 0; n < 40; n++) begin
            @(posedge clk); #2;
            if (done) return;
        end
        chk("R6 done never seen", 64'd0, 64'd1);
    endtask

    task automatic write_tol(input logic [7:0] v);
        @(negedge clk) begin tol_wr_en = 1'b1; tol_wr_pct = v; end
        @(negedge clk) tol_wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int dc0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: reset state
        chk("R1 dev_flags reset", 64'(dev_flags), 64'd0);
        chk("R1 tamper reset", 64'(tamper), 64'd0);
        chk("R1 done reset", 64'(done), 64'd0);
        chk("R1 busy reset", 64'(busy), 64'd0);

        // Matching run at default tolerance
        for (int i = 0; i < NE; i++) set_ev(i, 64'(i * 1000 + 7), 64'(i * 1000 + 7));
        pulse_start();
        wait_done();
        chk("R2 all matching flags", 64'(dev_flags), 64'd0);
        chk("R4 matching tamper", 64'(tamper), 64'd0);

        // Boundaries at 5 % (also proves R1 reset tolerance)
        set_ev(0, 64'd1050, 64'd1000);
        set_ev(1, 64'd1051, 64'd1000);
        set_ev(2, 64'd0,    64'd0);
        set_ev(3, 64'd1,    64'd0);
        set_ev(4, 64'd950,  64'd1000);
        set_ev(5, 64'd949,  64'd1000);
        pulse_start();
        @(posedge clk); @(posedge clk); #2;
        chk("R5 order after two evaluations", 64'(dev_flags), 64'b000010);
        wait_done();
        chk("R2/R3 boundary flags", 64'(dev_flags), 64'b101010);
        chk("R4 tamper on any deviation", 64'(tamper), 64'd1);

        // R8: hold after done
        repeat (5) @(negedge clk);
        chk("R8 flags held", 64'(dev_flags), 64'b101010);
        chk("R8 tamper held", 64'(tamper), 64'd1);

        // R8 clear on start, R7 start while busy ignored
        for (int i = 0; i < NE; i++) set_ev(i, 64'd500, 64'd500);
        dc0 = done_cnt;
        @(negedge clk) start = 1'b1;
        @(posedge clk); #2;
        chk("R8 flags cleared by start", 64'(dev_flags), 64'd0);
        chk("R8 tamper cleared by start", 64'(tamper), 64'd0);
        @(negedge clk) start = 1'b0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_done();
        repeat (10) @(negedge clk);
        chk("R7 single done for run", 64'(done_cnt - dc0), 64'd1);
        chk("R7 idle after run", 64'(busy), 64'd0);

        // R10: inputs change mid-run
        for (int i = 0; i < NE; i++) set_ev(i, 64'd800, 64'd800);
        pulse_start();
        for (int i = 0; i < NE; i++) set_ev(i, 64'd0, 64'd800);
        wait_done();
        chk("R10 snapshot ignores later inputs", 64'(dev_flags), 64'd0);

        // R9: tolerance write during busy dropped
        for (int i = 0; i < NE; i++) set_ev(i, 64'd1000, 64'd1000);
        set_ev(0, 64'd1080, 64'd1000);
        pulse_start();
        write_tol(8'd10);
        wait_done();
        chk("R9 busy write dropped", 64'(dev_flags), 64'b000001);

        // R9: idle write takes effect
        write_tol(8'd10);
        set_ev(0, 64'd1080, 64'd1000);
        set_ev(1, 64'd1101, 64'd1000);
        set_ev(2, 64'd1100, 64'd1000);
        pulse_start();
        wait_done();
        chk("R9 new tolerance used", 64'(dev_flags), 64'b000010);

        // R2: full-scale values without overflow (tol 10)
        for (int i = 0; i < NE; i++) set_ev(i, 64'd0, 64'd0);
        set_ev(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        set_ev(1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        set_ev(2, 64'h8000_0000_0000_0000 + 64'd922337203685477580, 64'h8000_0000_0000_0000);
        set_ev(3, 64'h8000_0000_0000_0000 + 64'd922337203685477581, 64'h8000_0000_0000_0000);
        pulse_start();
        wait_done();
        chk("R2 wide values no overflow", 64'(dev_flags), 64'b001010);
        chk("R4 tamper wide", 64'(tamper), 64'd1);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule